// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns one 16-bit compressed instruction into the single full-length base operation it stands for, delivered as separate decoded fields: an operation class, destination and two source register numbers, a 32-bit immediate, a memory access size and a flag that selects the floating-point register file. The fields feed an ordinary base-instruction decoder or issue stage, so compressed and full-length code can share one execution path. Executing the operation and checking memory alignment are left to later stages.

Several short forms collapse onto one base operation. Increment, load-immediate and move all become an add-immediate. The two-operand add and subtract forms are destructive and reuse the destination as a source. The dense 3-bit register fields reach only eight registers, through a non-contiguous table. The store-data and branch-compare source use a second table that swaps register 7 for the zero register. Any code outside the assigned opcodes raises an illegal flag, and every other field is then zero.

A parameter `REG_OUT` selects a registered output with one cycle of latency (default) or a purely combinational path. The block holds no state other than that optional register.

Top module: `cx_expander`

## Requirements
- R1: The major opcode is instr[4:0]. Every code whose low two bits are 11, and opcode 30, sets `illegal`=1, and `op_class`, `rd`, `rs1`, `rs2`, `imm`, `mem_dword` and `fp_reg` are all 0. Fields that an operation does not use are 0. `op_class` encoding: NONE 0, ADDI 1, ADDIW 2, ADD 3, SUB 4, OR 5, AND 6, SLLI 7, SRLI 8, SRAI 9, SLLIW 10, LOAD 11, STORE 12, BEQ 13, BNE 14, JAL 15, JALR 16.
- R2: A 3-bit general register field maps code 0 to x20, code 1 to x21 and codes 2..7 to x2..x7. The store-data and branch-compare field maps the same way, except that code 7 gives x0.
- R3: Opcode 0 (increment) gives ADDI rd,rd,imm, with rd=instr[9:5] and imm the sign extension of instr[15:10]; rd=0 is illegal. Opcode 1 gives ADDIW rd,rd,imm with the same fields, and rd=0 is allowed. Opcode 2 gives ADDI rd,x0,imm.
- R4: Stack-relative accesses use rs1=x30 and imm = zero-extended instr[15:10] scaled by 4 (word) or 8 (double). Opcode 4 is a word load into rd=instr[9:5]. Opcode 5 is a double load. Opcode 6 is a word store of rs2=instr[9:5]. Opcode 8 is a double store.
- R5: Opcode 9 is a register-indirect load: rd=instr[9:5], rs1=instr[14:10], imm=0, and `mem_dword`=instr[15].
- R6: Opcode 10 is destructive: rd=instr[9:5], rs1=instr[14:10], rs2=rd, with ADD when instr[15]=0 and SUB when it is 1. Opcode 12 with instr[15]=0 is a move: ADDI rd=instr[9:5], rs1=instr[14:10], imm=0.
- R7: Opcode 14 writes rda=map(instr[15:13]) from rs1a=map(instr[12:10]) and rs2a=map(instr[7:5]). instr[9:8] selects the operation: 00 ADD, 01 SUB, 10 OR, 11 AND.
- R8: Opcode 16 is a destructive shift on rd=rs1=map(instr[15:13]), with imm = zero-extended shamt instr[10:5]. instr[12:11] selects the shift: 00 SLLI, 01 SRLI, 10 SLLIW, 11 SRAI. SLLIW with shamt bit 5 set is illegal.
- R9: Register-relative accesses use rs1=map(instr[12:10]) and imm = zero-extended instr[9:5] scaled by 4 or 8. Loads write rd=map(instr[15:13]): 17 word, 18 double, 20 fp word, 21 fp double. Stores read rs2=zero-substituting map(instr[15:13]): 22 word, 24 double, 25 fp word, 26 fp double. `fp_reg`=1 only for opcodes 20, 21, 25 and 26.
- R10: Opcodes 28 (BEQ) and 29 (BNE) compare rs1=map(instr[12:10]) with rs2=zero-substituting map(instr[15:13]). imm is the sign extension of instr[9:5] shifted left by one, and rd=0.
- R11: Opcode 12 with instr[15]=1 is JAL with rd=0 and imm = the sign extension of instr[14:5] shifted left by one. Opcode 13 is JALR with rs1=instr[14:10] and imm=0, and rd is x0 when instr[15]=0 and x1 when it is 1.
- R12: With `REG_OUT`=1 every output reflects the instruction sampled at the previous rising clock edge. While `rst_n` is low all outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| instr | input | 16 | Compressed instruction |
| illegal | output | 1 | Unassigned or reserved encoding |
| op_class | output | 5 | Base operation class |
| rd | output | 5 | Destination register number |
| rs1 | output | 5 | First source register number |
| rs2 | output | 5 | Second source register number |
| imm | output | 32 | Extended and scaled immediate |
| mem_dword | output | 1 | Access size: 0 word, 1 double |
| fp_reg | output | 1 | Data register is floating-point |

## Verification
With the default registered output, the expansion of a code appears one rising edge after the code is presented. The bench drives each code on a falling edge and compares one nanosecond after the next rising edge, so no sample falls at an edge. All 65536 codes pass through in turn, and each result is compared with an arithmetic model of the field rules. Reset is checked twice. Once with an illegal code held at the input, to show that the register stays at zero. Once after the sweep, to show that reset clears live data.

// File: rtl/cx_pkg.sv
package cx_pkg;
    localparam int ILEN   = 16;
    localparam int REGW   = 5;
    localparam int IMMW   = 32;
    localparam int OPW    = 5;
    localparam int SELW   = 3;

    localparam logic [REGW-1:0] REG_SP = 5'd30;
    localparam logic [REGW-1:0] REG_RA = 5'd1;

    typedef enum logic [OPW-1:0] {
        CLS_NONE  = 5'd0,
        CLS_ADDI  = 5'd1,
        CLS_ADDIW = 5'd2,
        CLS_ADD   = 5'd3,
        CLS_SUB   = 5'd4,
        CLS_OR    = 5'd5,
        CLS_AND   = 5'd6,
        CLS_SLLI  = 5'd7,
        CLS_SRLI  = 5'd8,
        CLS_SRAI  = 5'd9,
        CLS_SLLIW = 5'd10,
        CLS_LOAD  = 5'd11,
        CLS_STORE = 5'd12,
        CLS_BEQ   = 5'd13,
        CLS_BNE   = 5'd14,
        CLS_JAL   = 5'd15,
        CLS_JALR  = 5'd16
    } op_class_e;

    typedef struct packed {
        logic            illegal;
        op_class_e       cls;
        logic [REGW-1:0] rd;
        logic [REGW-1:0] rs1;
        logic [REGW-1:0] rs2;
        logic [IMMW-1:0] imm;
        logic            dword;
        logic            fp;
    } xfields_t;

    localparam logic [4:0] OPC_INC   = 5'd0;
    localparam logic [4:0] OPC_INCW  = 5'd1;
    localparam logic [4:0] OPC_LDI   = 5'd2;
    localparam logic [4:0] OPC_LWSP  = 5'd4;
    localparam logic [4:0] OPC_LDSP  = 5'd5;
    localparam logic [4:0] OPC_SWSP  = 5'd6;
    localparam logic [4:0] OPC_SDSP  = 5'd8;
    localparam logic [4:0] OPC_IND   = 5'd9;
    localparam logic [4:0] OPC_R2    = 5'd10;
    localparam logic [4:0] OPC_MVJ   = 5'd12;
    localparam logic [4:0] OPC_JR    = 5'd13;
    localparam logic [4:0] OPC_R3    = 5'd14;
    localparam logic [4:0] OPC_SHF   = 5'd16;
    localparam logic [4:0] OPC_LW    = 5'd17;
    localparam logic [4:0] OPC_LD    = 5'd18;
    localparam logic [4:0] OPC_FLW   = 5'd20;
    localparam logic [4:0] OPC_FLD   = 5'd21;
    localparam logic [4:0] OPC_SW    = 5'd22;
    localparam logic [4:0] OPC_SD    = 5'd24;
    localparam logic [4:0] OPC_FSW   = 5'd25;
    localparam logic [4:0] OPC_FSD   = 5'd26;
    localparam logic [4:0] OPC_BEQ   = 5'd28;
    localparam logic [4:0] OPC_BNE   = 5'd29;
endpackage

// File: rtl/cx_regmap.sv
module cx_regmap
    import cx_pkg::*;
#(
    parameter bit ZERO_SUB = 1'b0
) (
    input  logic [SELW-1:0] code,
    output logic [REGW-1:0] idx
);
    localparam logic [REGW-1:0] LOW_BASE = 5'd20;
    localparam logic [SELW-1:0] TOP_CODE = SELW'((1 << SELW) - 1);

    logic [REGW-1:0] plain;

    always_comb begin
        if (code < SELW'(2)) plain = LOW_BASE + REGW'(code);
        else                 plain = REGW'(code);
    end

    generate
        if (ZERO_SUB) begin : g_zsub
            assign idx = (code == TOP_CODE) ? '0 : plain;
        end else begin : g_plain
            assign idx = plain;
        end
    endgenerate
endmodule

// File: rtl/cx_decode.sv
module cx_decode
    import cx_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    input  logic [REGW-1:0] ra_hi,
    input  logic [REGW-1:0] ra_mid,
    input  logic [REGW-1:0] ra_lo,
    input  logic [REGW-1:0] rb_hi,
    output xfields_t        fld
);
    logic [4:0]      opc;
    logic [REGW-1:0] rfull_a;
    logic [REGW-1:0] rfull_b;
    logic [IMMW-1:0] imm6_s, imm6_w, imm6_d, imm5_w, imm5_d, br_off, jmp_off, shamt;
    xfields_t        raw;
    logic            bad;

    assign opc     = instr[4:0];
    assign rfull_a = instr[9:5];
    assign rfull_b = instr[14:10];
    assign imm6_s  = {{26{instr[15]}}, instr[15:10]};
    assign imm6_w  = {24'b0, instr[15:10], 2'b0};
    assign imm6_d  = {23'b0, instr[15:10], 3'b0};
    assign imm5_w  = {25'b0, instr[9:5], 2'b0};
    assign imm5_d  = {24'b0, instr[9:5], 3'b0};
    assign br_off  = {{26{instr[9]}}, instr[9:5], 1'b0};
    assign jmp_off = {{21{instr[14]}}, instr[14:5], 1'b0};
    assign shamt   = {26'b0, instr[10:5]};

    always_comb begin
        raw = '0;
        bad = 1'b0;
        case (opc)
            OPC_INC: begin
                raw.cls = CLS_ADDI; raw.rd = rfull_a; raw.rs1 = rfull_a; raw.imm = imm6_s;
                bad = (rfull_a == '0);
            end
            OPC_INCW: begin
                raw.cls = CLS_ADDIW; raw.rd = rfull_a; raw.rs1 = rfull_a; raw.imm = imm6_s;
            end
            OPC_LDI: begin
                raw.cls = CLS_ADDI; raw.rd = rfull_a; raw.imm = imm6_s;
            end
            OPC_LWSP, OPC_LDSP: begin
                raw.cls   = CLS_LOAD; raw.rd = rfull_a; raw.rs1 = REG_SP;
                raw.dword = (opc == OPC_LDSP);
                raw.imm   = raw.dword ? imm6_d : imm6_w;
            end
            OPC_SWSP, OPC_SDSP: begin
                raw.cls   = CLS_STORE; raw.rs2 = rfull_a; raw.rs1 = REG_SP;
                raw.dword = (opc == OPC_SDSP);
                raw.imm   = raw.dword ? imm6_d : imm6_w;
            end
            OPC_IND: begin
                raw.cls = CLS_LOAD; raw.rd = rfull_a; raw.rs1 = rfull_b; raw.dword = instr[15];
            end
            OPC_R2: begin
                raw.cls = instr[15] ? CLS_SUB : CLS_ADD;
                raw.rd  = rfull_a; raw.rs1 = rfull_b; raw.rs2 = rfull_a;
            end
            OPC_MVJ: begin
                if (instr[15]) begin
                    raw.cls = CLS_JAL; raw.imm = jmp_off;
                end else begin
                    raw.cls = CLS_ADDI; raw.rd = rfull_a; raw.rs1 = rfull_b;
                end
            end
            OPC_JR: begin
                raw.cls = CLS_JALR; raw.rs1 = rfull_b;
                raw.rd  = instr[15] ? REG_RA : '0;
            end
            OPC_R3: begin
                raw.rd = ra_hi; raw.rs1 = ra_mid; raw.rs2 = ra_lo;
                case (instr[9:8])
                    2'b00:   raw.cls = CLS_ADD;
                    2'b01:   raw.cls = CLS_SUB;
                    2'b10:   raw.cls = CLS_OR;
                    default: raw.cls = CLS_AND;
                endcase
            end
            OPC_SHF: begin
                raw.rd = ra_hi; raw.rs1 = ra_hi; raw.imm = shamt;
                case (instr[12:11])
                    2'b00:   raw.cls = CLS_SLLI;
                    2'b01:   raw.cls = CLS_SRLI;
                    2'b10: begin
                        raw.cls = CLS_SLLIW;
                        bad     = instr[10];
                    end
                    default: raw.cls = CLS_SRAI;
                endcase
            end
            OPC_LW, OPC_LD, OPC_FLW, OPC_FLD: begin
                raw.cls   = CLS_LOAD; raw.rd = ra_hi; raw.rs1 = ra_mid;
                raw.dword = (opc == OPC_LD) || (opc == OPC_FLD);
                raw.fp    = (opc == OPC_FLW) || (opc == OPC_FLD);
                raw.imm   = raw.dword ? imm5_d : imm5_w;
            end
            OPC_SW, OPC_SD, OPC_FSW, OPC_FSD: begin
                raw.cls   = CLS_STORE; raw.rs2 = rb_hi; raw.rs1 = ra_mid;
                raw.dword = (opc == OPC_SD) || (opc == OPC_FSD);
                raw.fp    = (opc == OPC_FSW) || (opc == OPC_FSD);
                raw.imm   = raw.dword ? imm5_d : imm5_w;
            end
            OPC_BEQ, OPC_BNE: begin
                raw.cls = (opc == OPC_BEQ) ? CLS_BEQ : CLS_BNE;
                raw.rs1 = ra_mid; raw.rs2 = rb_hi; raw.imm = br_off;
            end
            default: bad = 1'b1;
        endcase
    end

    always_comb begin
        if (bad) begin
            fld         = '0;
            fld.illegal = 1'b1;
        end else begin
            fld = raw;
        end
    end
endmodule

// File: rtl/cx_outreg.sv
module cx_outreg
    import cx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  xfields_t d,
    output xfields_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

    // R1
    illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.illegal |-> (q.cls == CLS_NONE && q.rd == '0 && q.rs1 == '0 &&
                       q.rs2 == '0 && q.imm == '0 && !q.dword && !q.fp));

    // R9
    fp_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.fp |-> (q.cls == CLS_LOAD || q.cls == CLS_STORE));

    // R4
    dword_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dword && (q.cls == CLS_LOAD || q.cls == CLS_STORE)) |-> (q.imm[2:0] == 3'b000));

    // R10
    branch_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cls == CLS_BEQ || q.cls == CLS_BNE) |-> (q.rd == '0 && !q.imm[0]));

    // R11
    jalr_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cls == CLS_JALR) |-> ((q.rd == '0 || q.rd == REG_RA) && q.imm == '0));

    // R2
    store_src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cls == CLS_STORE && q.rs1 != REG_SP) |-> (q.rs2 <= 5'd6 || q.rs2 == 5'd20 || q.rs2 == 5'd21));
endmodule

// File: rtl/cx_expander.sv
module cx_expander
    import cx_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] instr,
    output logic        illegal,
    output logic [4:0]  op_class,
    output logic [4:0]  rd,
    output logic [4:0]  rs1,
    output logic [4:0]  rs2,
    output logic [31:0] imm,
    output logic        mem_dword,
    output logic        fp_reg
);
    logic [REGW-1:0] ra_hi, ra_mid, ra_lo, rb_hi;
    xfields_t        dec, res;

    cx_regmap #(.ZERO_SUB(1'b0)) i_map_hi  (.code(instr[15:13]), .idx(ra_hi));
    cx_regmap #(.ZERO_SUB(1'b0)) i_map_mid (.code(instr[12:10]), .idx(ra_mid));
    cx_regmap #(.ZERO_SUB(1'b0)) i_map_lo  (.code(instr[7:5]),   .idx(ra_lo));
    cx_regmap #(.ZERO_SUB(1'b1)) i_map_src (.code(instr[15:13]), .idx(rb_hi));

    cx_decode i_decode (
        .instr (instr),
        .ra_hi (ra_hi),
        .ra_mid(ra_mid),
        .ra_lo (ra_lo),
        .rb_hi (rb_hi),
        .fld   (dec)
    );

    cx_outreg #(.REG_OUT(REG_OUT)) i_outreg (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (dec),
        .q    (res)
    );

    assign illegal   = res.illegal;
    assign op_class  = res.cls;
    assign rd        = res.rd;
    assign rs1       = res.rs1;
    assign rs2       = res.rs2;
    assign imm       = res.imm;
    assign mem_dword = res.dword;
    assign fp_reg    = res.fp;
endmodule

// File: tb/test_cx_expander.sv
`timescale 1ns/1ps
module test_cx_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        illegal, mem_dword, fp_reg;
    logic [4:0]  op_class, rd, rs1, rs2;
    logic [31:0] imm;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cx_expander i_cx_expander (
        .clk(clk), .rst_n(rst_n), .instr(instr),
        .illegal(illegal), .op_class(op_class), .rd(rd), .rs1(rs1), .rs2(rs2),
        .imm(imm), .mem_dword(mem_dword), .fp_reg(fp_reg)
    );

    typedef struct {
        bit    ill;
        int    cls;
        int    rd;
        int    rs1;
        int    rs2;
        int    imm;
        bit    dw;
        bit    fp;
        string tag;
    } exp_t;

    function automatic int map3(int c, bit zsub);
        if (c < 2)              return 20 + c;
        if (zsub && c == 7)     return 0;
        return c;
    endfunction

    function automatic int sx(int v, int bits);
        if (v >= (1 << (bits - 1))) return v - (1 << bits);
        return v;
    endfunction

    function automatic exp_t model(int w);
        exp_t e;
        int op  = w % 32;
        int f5a = (w / 32) % 32;
        int f5b = (w / 1024) % 32;
        int top = (w / 32768) % 2;
        int i6  = (w / 1024) % 64;
        int i5  = (w / 32) % 32;
        int hi3 = (w / 8192) % 8;
        int md3 = (w / 1024) % 8;
        int lo3 = (w / 32) % 8;
        e = '{ill: 0, cls: 0, rd: 0, rs1: 0, rs2: 0, imm: 0, dw: 0, fp: 0, tag: "R1"};
        case (op)
            0:  begin e.tag = "R3"; if (f5a == 0) e.ill = 1;
                      else begin e.cls = 1; e.rd = f5a; e.rs1 = f5a; e.imm = sx(i6, 6); end end
            1:  begin e.tag = "R3"; e.cls = 2; e.rd = f5a; e.rs1 = f5a; e.imm = sx(i6, 6); end
            2:  begin e.tag = "R3"; e.cls = 1; e.rd = f5a; e.imm = sx(i6, 6); end
            4, 5: begin e.tag = "R4"; e.cls = 11; e.rd = f5a; e.rs1 = 30; e.dw = (op == 5);
                      e.imm = i6 * (e.dw ? 8 : 4); end
            6, 8: begin e.tag = "R4"; e.cls = 12; e.rs2 = f5a; e.rs1 = 30; e.dw = (op == 8);
                      e.imm = i6 * (e.dw ? 8 : 4); end
            9:  begin e.tag = "R5"; e.cls = 11; e.rd = f5a; e.rs1 = f5b; e.dw = top[0]; end
            10: begin e.tag = "R6"; e.cls = top ? 4 : 3; e.rd = f5a; e.rs1 = f5b; e.rs2 = f5a; end
            12: if (top == 0) begin e.tag = "R6"; e.cls = 1; e.rd = f5a; e.rs1 = f5b; end
                else begin e.tag = "R11"; e.cls = 15; e.imm = 2 * sx((w / 32) % 1024, 10); end
            13: begin e.tag = "R11"; e.cls = 16; e.rs1 = f5b; e.rd = top ? 1 : 0; end
            14: begin e.tag = "R2/R7"; e.rd = map3(hi3, 0); e.rs1 = map3(md3, 0);
                      e.rs2 = map3(lo3, 0); e.cls = 3 + (w / 256) % 4; end
            16: begin
                    int fn = (w / 2048) % 4;
                    int sh = (w / 32) % 64;
                    e.tag = "R8";
                    if (fn == 2 && sh >= 32) e.ill = 1;
                    else begin
                        e.rd = map3(hi3, 0); e.rs1 = e.rd; e.imm = sh;
                        e.cls = (fn == 0) ? 7 : (fn == 1) ? 8 : (fn == 2) ? 10 : 9;
                    end
                end
            17, 18, 20, 21: begin e.tag = "R2/R9"; e.cls = 11; e.rd = map3(hi3, 0);
                      e.rs1 = map3(md3, 0); e.dw = (op == 18 || op == 21);
                      e.fp = (op >= 20); e.imm = i5 * (e.dw ? 8 : 4); end
            22, 24, 25, 26: begin e.tag = "R2/R9"; e.cls = 12; e.rs2 = map3(hi3, 1);
                      e.rs1 = map3(md3, 0); e.dw = (op == 24 || op == 26);
                      e.fp = (op >= 25); e.imm = i5 * (e.dw ? 8 : 4); end
            28, 29: begin e.tag = "R2/R10"; e.cls = (op == 28) ? 13 : 14;
                      e.rs1 = map3(md3, 0); e.rs2 = map3(hi3, 1); e.imm = 2 * sx(i5, 5); end
            default: e.ill = 1;
        endcase
        return e;
    endfunction

    task automatic compare(exp_t e, int w);
        checks++;
        if (illegal !== e.ill || op_class !== 5'(e.cls) || rd !== 5'(e.rd) ||
            rs1 !== 5'(e.rs1) || rs2 !== 5'(e.rs2) || imm !== 32'(e.imm) ||
            mem_dword !== e.dw || fp_reg !== e.fp) begin
            errors++;
            $display("FAIL %s code=%h actual ill=%0d cls=%0d rd=%0d rs1=%0d rs2=%0d imm=%h dw=%0d fp=%0d expected ill=%0d cls=%0d rd=%0d rs1=%0d rs2=%0d imm=%h dw=%0d fp=%0d",
                     e.tag, w[15:0], illegal, op_class, rd, rs1, rs2, imm, mem_dword, fp_reg,
                     e.ill, e.cls, e.rd, e.rs1, e.rs2, 32'(e.imm), e.dw, e.fp);
        end
    endtask

    task automatic check_zero(string what);
        exp_t z = '{ill: 0, cls: 0, rd: 0, rs1: 0, rs2: 0, imm: 0, dw: 0, fp: 0, tag: what};
        compare(z, int'(instr));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired before the sweep ended");
        finish_run();
    end

    initial begin
        // R12: reset holds outputs at zero even with an illegal code presented
        instr = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        check_zero("R12 reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1..R11 and R12 latency: each code is due one rising edge after it is driven
        for (int w = 0; w < 65536; w++) begin
            @(negedge clk);
            instr = w[15:0];
            @(posedge clk);
            #1;
            compare(model(w), w);
        end
        // R12: reset clears live data
        @(negedge clk);
        instr = 16'h0441;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check_zero("R12 clear");
        finish_run();
    end
endmodule